// File: doc/BRIEF.md
# 8-bit Accumulator ALU with Flag Register

This block is the arithmetic and logic stage of a small accumulator-oriented processor. Each cycle it takes an accumulator operand, a memory operand, a carry input, a decimal-mode bit and a 4-bit operation code. From these it produces an 8-bit result, a strobe that says whether the result should be written back, and four candidate flags: negative, overflow, zero and carry. Each candidate flag has its own update enable. The block does not decode instructions and holds no data registers.

The result path is purely combinational. The four flags live in a small register inside the block. On a clock edge where `alu_go` is high, each flag whose enable is set takes its new value, and every other flag keeps its old value. Only binary arithmetic is implemented. The decimal-mode input is accepted at the port but has no effect on any output.

Flags are packed as {N, V, Z, C}, bit 3 down to bit 0, in `flag_en` and in `flags_q`.

Top module: `acc_alu`

## Requirements
- R1: While reset is low, and right after it is released, `flags_q` reads 4'b0000.
- R2: Code 0 (add) gives result = (A + M + cin) mod 256. C is 1 when the unsigned sum exceeds 255. V is 1 when A and M have the same sign and the result's sign differs. N is result bit 7 and Z is (result == 0). All four flag enables are 1 and `res_wr` is 1.
- R3: Code 1 (subtract) gives result = (A - M - (1 - cin)) mod 256. C is 1 when no borrow occurred and 0 when a borrow occurred. V is 1 when A and M have opposite signs and the signed result falls outside -128..127. N and Z follow the result. All four enables are 1 and `res_wr` is 1.
- R4: Codes 2, 3 and 4 give A AND M, A OR M and A XOR M. Only N (result bit 7) and Z (result zero) are enabled. V and C keep their stored values.
- R5: Code 5 (compare) sets N=1, Z=0, C=0 when A < M; N=0, Z=1, C=1 when A == M; and N=0, Z=0, C=1 when A > M. The comparison is unsigned and `cin` is ignored. V is not enabled and `res_wr` is 0.
- R6: Code 6 (bit test) sets N to M bit 7, V to M bit 6 and Z to ((A AND M) == 0). C is not enabled and `res_wr` is 0.
- R7: Code 7 (shift left) moves A bit 7 into C and fills bit 0 with 0. Code 8 (logical shift right) moves A bit 0 into C, fills bit 7 with 0 and always clears N. Both enable N, Z and C.
- R8: Code 9 (rotate left) puts `cin` in bit 0 and A bit 7 in C. Code 10 (rotate right) puts `cin` in bit 7 and A bit 0 in C. Both enable N, Z and C.
- R9: Codes 11 to 15 enable no flag and drive `res_wr` 0. When `alu_go` is low, or when the code is one of these, `flags_q` does not change at the next edge.
- R10: `dec_mode` has no effect on any output.
- R11: `result`, `res_wr`, `flag_nxt` and `flag_en` follow the inputs in the same cycle. `flags_q` takes the enabled flags at the rising edge where `alu_go` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of the flag register |
| alu_go | input | 1 | Commit enabled flags at this edge |
| op_sel | input | 4 | Operation code |
| opnd_a | input | 8 | Accumulator operand |
| opnd_m | input | 8 | Memory operand |
| cin | input | 1 | Carry input |
| dec_mode | input | 1 | Decimal-mode bit (no effect) |
| result | output | 8 | Operation result |
| res_wr | output | 1 | Result should be written back |
| flag_nxt | output | 4 | Candidate flags {N,V,Z,C} |
| flag_en | output | 4 | Per-flag update enables {N,V,Z,C} |
| flags_q | output | 4 | Registered flags {N,V,Z,C} |

## Verification
The result, the write strobe, the candidate flags and the enables are combinational. The bench therefore drives operands just after a falling edge and checks those outputs one time unit later, before the next rising edge. The registered flags are due one rising edge after a cycle with `alu_go` high. The bench samples them one time unit after that edge and compares them with a flag state it tracks itself, updating only the flags that the requirements enable. Stretches with `alu_go` low, and the unused codes, are checked by confirming that the sampled flags match the previous value.

// File: rtl/acc_alu.sv
module acc_alu (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       alu_go,
  input  logic [3:0] op_sel,
  input  logic [7:0] opnd_a,
  input  logic [7:0] opnd_m,
  input  logic       cin,
  input  logic       dec_mode,
  output logic [7:0] result,
  output logic       res_wr,
  output logic [3:0] flag_nxt,
  output logic [3:0] flag_en,
  output logic [3:0] flags_q
);

  localparam logic [3:0] OP_ADD = 4'd0;
  localparam logic [3:0] OP_SUB = 4'd1;
  localparam logic [3:0] OP_AND = 4'd2;
  localparam logic [3:0] OP_OR  = 4'd3;
  localparam logic [3:0] OP_XOR = 4'd4;
  localparam logic [3:0] OP_CMP = 4'd5;
  localparam logic [3:0] OP_BIT = 4'd6;
  localparam logic [3:0] OP_ASL = 4'd7;
  localparam logic [3:0] OP_LSR = 4'd8;
  localparam logic [3:0] OP_ROL = 4'd9;
  localparam logic [3:0] OP_ROR = 4'd10;

  logic [8:0] sum9, dif9, cmp9;
  logic       v_add, v_sub;
  logic       n_f, v_f, z_f, c_f;

  assign sum9  = {1'b0, opnd_a} + {1'b0, opnd_m} + {8'd0, cin};
  assign dif9  = {1'b0, opnd_a} + {1'b0, ~opnd_m} + {8'd0, cin};
  assign cmp9  = {1'b0, opnd_a} + {1'b0, ~opnd_m} + 9'd1;
  assign v_add = (opnd_a[7] == opnd_m[7]) && (sum9[7] != opnd_a[7]);
  assign v_sub = (opnd_a[7] != opnd_m[7]) && (dif9[7] != opnd_a[7]);

  always_comb begin
    result  = opnd_a;
    res_wr  = 1'b0;
    flag_en = 4'b0000;
    n_f     = 1'b0;
    v_f     = 1'b0;
    c_f     = 1'b0;
    case (op_sel)
      OP_ADD: begin
        result = sum9[7:0]; res_wr = 1'b1; flag_en = 4'b1111;
        v_f = v_add; c_f = sum9[8];
      end
      OP_SUB: begin
        result = dif9[7:0]; res_wr = 1'b1; flag_en = 4'b1111;
        v_f = v_sub; c_f = dif9[8];
      end
      OP_AND: begin result = opnd_a & opnd_m; res_wr = 1'b1; flag_en = 4'b1010; end
      OP_OR:  begin result = opnd_a | opnd_m; res_wr = 1'b1; flag_en = 4'b1010; end
      OP_XOR: begin result = opnd_a ^ opnd_m; res_wr = 1'b1; flag_en = 4'b1010; end
      OP_CMP: begin
        result = cmp9[7:0]; flag_en = 4'b1011; c_f = cmp9[8];
      end
      OP_BIT: begin
        result = opnd_a & opnd_m; flag_en = 4'b1110;
        v_f = opnd_m[6];
      end
      OP_ASL: begin
        result = {opnd_a[6:0], 1'b0}; res_wr = 1'b1; flag_en = 4'b1011;
        c_f = opnd_a[7];
      end
      OP_LSR: begin
        result = {1'b0, opnd_a[7:1]}; res_wr = 1'b1; flag_en = 4'b1011;
        c_f = opnd_a[0];
      end
      OP_ROL: begin
        result = {opnd_a[6:0], cin}; res_wr = 1'b1; flag_en = 4'b1011;
        c_f = opnd_a[7];
      end
      OP_ROR: begin
        result = {cin, opnd_a[7:1]}; res_wr = 1'b1; flag_en = 4'b1011;
        c_f = opnd_a[0];
      end
      default: ;
    endcase
    case (op_sel)
      OP_CMP:  n_f = !cmp9[8];
      OP_BIT:  n_f = opnd_m[7];
      default: n_f = result[7];
    endcase
  end

  assign z_f      = (result == 8'd0);
  assign flag_nxt = {n_f, v_f, z_f, c_f};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags_q <= 4'b0000;
    end else if (alu_go) begin
      for (int i = 0; i < 4; i++)
        if (flag_en[i]) flags_q[i] <= flag_nxt[i];
    end
  end

  AST_RESET_CLEAR: assert property (@(posedge clk) !rst_n |=> flags_q == 4'b0000); // R1
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !alu_go |=> flags_q == $past(flags_q)); // R9
  AST_LOGIC_KEEP_VC: assert property (@(posedge clk) disable iff (!rst_n)
    alu_go && (op_sel == OP_AND || op_sel == OP_OR || op_sel == OP_XOR)
    |=> flags_q[2] == $past(flags_q[2]) && flags_q[0] == $past(flags_q[0])); // R4
  AST_CMP_EQUAL: assert property (@(posedge clk) disable iff (!rst_n)
    alu_go && op_sel == OP_CMP && opnd_a == opnd_m |=> flags_q[1] && flags_q[0] && !flags_q[3]); // R5
  AST_BIT_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    alu_go && op_sel == OP_BIT |=> flags_q[3:2] == $past(opnd_m[7:6])); // R6
  AST_LSR_NCLR: assert property (@(posedge clk) disable iff (!rst_n)
    alu_go && op_sel == OP_LSR |=> !flags_q[3]); // R7
  AST_DEC_BINARY: assert property (@(posedge clk) disable iff (!rst_n)
    alu_go && dec_mode && op_sel == OP_ADD && opnd_a == 8'h09 && opnd_m == 8'h01 && !cin
    |=> !flags_q[1] && !flags_q[0]); // R10

endmodule

// File: tb/acc_alu_tb.sv
module acc_alu_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       alu_go = 1'b0;
  logic [3:0] op_sel = 4'd0;
  logic [7:0] opnd_a = 8'd0, opnd_m = 8'd0;
  logic       cin = 1'b0, dec_mode = 1'b0;
  logic [7:0] result;
  logic       res_wr;
  logic [3:0] flag_nxt, flag_en, flags_q;

  int checks = 0, fails = 0;
  logic [3:0] exp_st = 4'b0000;
  bit done = 0;

  acc_alu dut_i (.clk(clk), .rst_n(rst_n), .alu_go(alu_go), .op_sel(op_sel),
    .opnd_a(opnd_a), .opnd_m(opnd_m), .cin(cin), .dec_mode(dec_mode),
    .result(result), .res_wr(res_wr), .flag_nxt(flag_nxt), .flag_en(flag_en),
    .flags_q(flags_q));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model(input logic [3:0] op, input logic [7:0] a, input logic [7:0] m,
                       input logic c, output logic [7:0] r, output logic wr,
                       output logic [3:0] en, output logic [3:0] f);
    int ua, um, s, sa, sm, ss;
    logic n, v, z, cc;
    ua = a; um = m;
    sa = a[7] ? ua - 256 : ua;
    sm = m[7] ? um - 256 : um;
    r = a; wr = 0; en = 0; v = 0; cc = 0;
    case (op)
      0: begin s = ua + um + c; r = s[7:0]; cc = s > 255; ss = sa + sm + c;
         v = ss > 127 || ss < -128; wr = 1; en = 4'hF; end
      1: begin s = ua - um - (1 - c); r = s[7:0]; cc = s >= 0; ss = sa - sm - (1 - c);
         v = ss > 127 || ss < -128; wr = 1; en = 4'hF; end
      2: begin r = a & m; wr = 1; en = 4'b1010; end
      3: begin r = a | m; wr = 1; en = 4'b1010; end
      4: begin r = a ^ m; wr = 1; en = 4'b1010; end
      5: en = 4'b1011;
      6: en = 4'b1110;
      7: begin r = a << 1; cc = a[7]; wr = 1; en = 4'b1011; end
      8: begin r = a >> 1; cc = a[0]; wr = 1; en = 4'b1011; end
      9: begin r = {a[6:0], c}; cc = a[7]; wr = 1; en = 4'b1011; end
      10: begin r = {c, a[7:1]}; cc = a[0]; wr = 1; en = 4'b1011; end
      default: ;
    endcase
    n = r[7]; z = (r == 0);
    if (op == 5) begin n = ua < um; z = ua == um; cc = ua >= um; end
    if (op == 6) begin n = m[7]; v = m[6]; z = (a & m) == 0; end
    f = {n, v, z, cc};
  endtask

  task automatic run_op(input string tag, input logic [3:0] op, input logic [7:0] a,
                        input logic [7:0] m, input logic c, input logic dm, input logic go);
    logic [7:0] r; logic wr; logic [3:0] en, f;
    @(negedge clk);
    op_sel = op; opnd_a = a; opnd_m = m; cin = c; dec_mode = dm; alu_go = go;
    model(op, a, m, c, r, wr, en, f);
    #1;
    if (wr) chk({tag, " result"}, result, r);
    chk({tag, " res_wr"}, res_wr, wr);
    chk({tag, " flag_en"}, flag_en, en);
    chk({tag, " flag_nxt"}, flag_nxt & en, f & en);
    if (go) for (int i = 0; i < 4; i++) if (en[i]) exp_st[i] = f[i];
    @(posedge clk); #1;
    alu_go = 0;
    chk({tag, " flags_q"}, flags_q, exp_st);
  endtask

  task automatic t_reset;
    rst_n = 0;
    repeat (3) @(posedge clk);
    #1 chk("R1 reset flags", flags_q, 4'b0000);
    @(negedge clk); rst_n = 1;
    @(posedge clk); #1 chk("R1 after release", flags_q, 4'b0000);
  endtask

  task automatic t_add;
    run_op("R2 add carry", 0, 8'hFF, 8'h01, 0, 0, 1);
    run_op("R2 add overflow", 0, 8'h7F, 8'h01, 0, 0, 1);
    run_op("R2 add cin", 0, 8'h10, 8'h20, 1, 0, 1);
    run_op("R2 add negovf", 0, 8'h80, 8'h80, 0, 0, 1);
  endtask

  task automatic t_sub;
    run_op("R3 sub noborrow", 1, 8'h50, 8'h10, 1, 0, 1);
    run_op("R3 sub borrow", 1, 8'h10, 8'h50, 1, 0, 1);
    run_op("R3 sub cin0", 1, 8'h05, 8'h05, 0, 0, 1);
    run_op("R3 sub overflow", 1, 8'h80, 8'h01, 1, 0, 1);
  endtask

  task automatic t_logic;
    run_op("R4 setup vc", 0, 8'h7F, 8'h81, 0, 0, 1);
    run_op("R4 and", 2, 8'hF0, 8'h0F, 0, 0, 1);
    run_op("R4 or", 3, 8'h80, 8'h08, 0, 0, 1);
    run_op("R4 xor", 4, 8'hAA, 8'hFF, 0, 0, 1);
  endtask

  task automatic t_cmp;
    run_op("R5 cmp less", 5, 8'h10, 8'h20, 1, 0, 1);
    run_op("R5 cmp equal", 5, 8'h42, 8'h42, 0, 0, 1);
    run_op("R5 cmp greater", 5, 8'hFF, 8'h01, 0, 0, 1);
  endtask

  task automatic t_bit;
    run_op("R6 bit zero", 6, 8'h80, 8'h7F, 0, 0, 1);
    run_op("R6 bit set", 6, 8'hFF, 8'hC1, 0, 0, 1);
  endtask

  task automatic t_shift;
    run_op("R7 asl", 7, 8'h81, 8'h00, 1, 0, 1);
    run_op("R7 lsr", 8, 8'hFF, 8'h00, 1, 0, 1);
    run_op("R7 lsr zero", 8, 8'h01, 8'h00, 0, 0, 1);
    run_op("R8 rol", 9, 8'h80, 8'h00, 1, 0, 1);
    run_op("R8 ror", 10, 8'h01, 8'h00, 1, 0, 1);
    run_op("R8 ror nocin", 10, 8'h02, 8'h00, 0, 0, 1);
  endtask

  task automatic t_idle;
    run_op("R9 prime", 0, 8'hFF, 8'h80, 0, 0, 1);
    run_op("R9 go low", 0, 8'h00, 8'h00, 0, 0, 0);
    for (int k = 11; k < 16; k++) run_op("R9 unused code", 4'(k), 8'h00, 8'h00, 1, 0, 1);
  endtask

  task automatic t_dec;
    run_op("R10 dec add", 0, 8'h09, 8'h01, 0, 1, 1);
    run_op("R10 dec sub", 1, 8'h10, 8'h01, 1, 1, 1);
  endtask

  task automatic t_random;
    for (int k = 0; k < 400; k++)
      run_op("R11 random", 4'($urandom_range(0, 15)), 8'($urandom), 8'($urandom),
             1'($urandom), 1'($urandom), 1'($urandom));
  endtask

  initial begin
    t_reset();
    t_add();
    t_sub();
    t_logic();
    t_cmp();
    t_bit();
    t_shift();
    t_idle();
    t_dec();
    t_random();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL R11 watchdog actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule